// File: doc/BRIEF.md
# Transmit Burst Activity Marker

This block watches a transmit sample stream and drives a single general-purpose output that is high while a transmit burst is in flight. It runs on a clock at twice the sample rate, so one clock cycle is one half-sample. A sample strobe marks the cycles that carry a sample, and a per-sample flag says whether that sample belongs to a burst. The marker pulse trails the burst by a fixed pipeline latency. Its length is rounded up to whole groups of four samples.

Two 16-bit delay values, both counted in half-sample steps (clock cycles), move the edges of the pulse. One shifts the rising edge later. The other shifts the falling edge later. A start delay that reaches past the last burst sample suppresses the pulse for that burst. Both delay values are taken while the stream is stopped and are frozen while it runs. This gives every burst in a session the same edge placement, with no jitter from one burst to the next.

Top module: `burst_marker`

## Requirements
- R1: While reset is asserted, and after it is released with the stream stopped, `gpioOut` is low.
- R2: With the stream running and no pulse pending, a burst starts at a clock edge where `sampleStb` and `burstActive` are both high. Its length T counts the strobed samples with `burstActive` high, up to the first strobed sample with the flag low. Levels of `burstActive` on cycles without the strobe are never sampled.
- R3: `gpioOut` rises 2*LAT + S clock edges after the burst's first strobed edge. LAT is the latency in samples (default 30) and S is the start delay in half-samples.
- R4: The un-delayed pulse covers G = ((T+3)/4)*4 samples, using integer division. `gpioOut` falls 2*LAT + 2*G + E edges after the burst's first edge, where E is the end delay in half-samples.
- R5: A pulse is produced only if S <= 2*(T-1). For a larger S, `gpioOut` stays low for that burst.
- R6: The delay inputs are copied on every edge while `streamRun` is low and held while it is high. Changing them during a session has no effect, so every burst in a session has the same rise and fall offsets.
- R7: From a burst's first edge until its scheduled fall edge, strobed active samples do not start a new burst. This holds even when the pulse is suppressed.
- R8: When `streamRun` is low at an edge, `gpioOut` is low after that edge. Any pending pulse is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rstN | input | 1 | Asynchronous reset, active low |
| streamRun | input | 1 | High while the stream session is running |
| sampleStb | input | 1 | High on cycles that carry a sample |
| burstActive | input | 1 | Burst flag of the current sample |
| startDly | input | 16 | Rising-edge delay in half-samples |
| endDly | input | 16 | Falling-edge delay in half-samples |
| gpioOut | output | 1 | Burst activity marker |

## Verification
The hardest case to reach is a burst that arrives while the block is still locked out behind a suppressed pulse, because nothing at the output shows that the lock-out exists. The stimulus uses a two-sample burst with a start delay above its limit. It then sends strobed active samples well before the scheduled fall point and expects no rise at all. The delay limit is tested at its exact boundary (S = 2*(T-1) and one step past it). The mid-session freeze is tested by rewriting both delay inputs between two bursts of one session and comparing the measured edge offsets.

// File: rtl/burst_marker_pkg.sv
package burst_marker_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic startBurst;  // load counters for a fresh burst
    logic runCnt;      // advance elapsed time and sample count
    logic clrAll;      // stream stopped: clear burst state
  } ctlStb_t;

  // status from datapath to control
  typedef struct packed {
    logic riseNow;     // elapsed time equals scheduled rise edge
    logic riseOk;      // start delay fits inside the burst
    logic fallNow;     // elapsed time equals scheduled fall edge
    logic burstDone;   // first inactive sample has been seen
  } dpSts_t;

endpackage

// File: rtl/burst_marker_dp.sv
module burst_marker_dp
  import burst_marker_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int CNT_W       = 16,
  parameter int LAT_SAMPLES = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             streamRun,
  input  logic             sampleStb,
  input  logic             burstActive,
  input  logic [DLY_W-1:0] startDlyIn,
  input  logic [DLY_W-1:0] endDlyIn,
  input  ctlStb_t          ctl,
  output dpSts_t           sts
);

  localparam int MAX_W   = (DLY_W > CNT_W) ? DLY_W : CNT_W;
  localparam int LAT_CYC = 2 * LAT_SAMPLES;
  localparam int ELAP_W  = MAX_W + $clog2(LAT_CYC + 2) + 3;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [ELAP_W-1:0] ELAP_MAX = '1;

  logic [DLY_W-1:0]  startDlyQ, endDlyQ;
  logic [CNT_W-1:0]  tCnt;
  logic              burstDone;
  logic [ELAP_W-1:0] elapsed;

  logic [ELAP_W-1:0] groupCnt;
  logic [ELAP_W-1:0] pulseHalf;
  logic [ELAP_W-1:0] riseAt, fallAt, riseLimit;

  // delay capture: follows the inputs while stopped, frozen while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startDlyQ <= '0;
      endDlyQ   <= '0;
    end else if (!streamRun) begin
      startDlyQ <= startDlyIn;
      endDlyQ   <= endDlyIn;
    end
  end

  // burst length and elapsed half-sample counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tCnt      <= '0;
      burstDone <= 1'b0;
      elapsed   <= '0;
    end else if (ctl.clrAll) begin
      tCnt      <= '0;
      burstDone <= 1'b0;
      elapsed   <= '0;
    end else if (ctl.startBurst) begin
      tCnt      <= CNT_W'(1);
      burstDone <= 1'b0;
      elapsed   <= ELAP_W'(1);
    end else if (ctl.runCnt) begin
      if (elapsed != ELAP_MAX) elapsed <= elapsed + ELAP_W'(1);
      if (!burstDone && sampleStb) begin
        if (burstActive) begin
          if (tCnt != CNT_MAX) tCnt <= tCnt + CNT_W'(1);
        end else begin
          burstDone <= 1'b1;
        end
      end
    end
  end

  // edge schedule in clock cycles counted from the first burst edge
  always_comb begin
    groupCnt  = (ELAP_W'(tCnt) + ELAP_W'(3)) >> 2;
    pulseHalf = groupCnt << 3;                       // 2 * 4 * groups
    riseAt    = ELAP_W'(LAT_CYC) + ELAP_W'(startDlyQ);
    fallAt    = ELAP_W'(LAT_CYC) + pulseHalf + ELAP_W'(endDlyQ);
    riseLimit = (tCnt == '0) ? '0 : ELAP_W'(tCnt - CNT_W'(1)) << 1;
  end

  always_comb begin
    sts.riseNow   = (elapsed == riseAt);
    sts.riseOk    = !burstDone || (ELAP_W'(startDlyQ) <= riseLimit);
    sts.fallNow   = burstDone && (elapsed == fallAt);
    sts.burstDone = burstDone;
  end

  // R6
  dly_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (streamRun && $past(streamRun)) |-> ($stable(startDlyQ) && $stable(endDlyQ)));

  // R2
  tcnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstDone && $past(burstDone) && $past(streamRun) && $past(!ctl.startBurst))
      |-> $stable(tCnt));

endmodule

// File: rtl/burst_marker_ctrl.sv
module burst_marker_ctrl
  import burst_marker_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    streamRun,
  input  logic    sampleStb,
  input  logic    burstActive,
  input  dpSts_t  sts,
  output ctlStb_t ctl,
  output logic    gpioQ
);

  typedef enum logic {S_IDLE, S_BUSY} state_t;

  state_t state, stateNext;
  logic   gpioNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    gpioNext  = gpioQ;
    if (!streamRun) begin
      ctl.clrAll = 1'b1;
      stateNext  = S_IDLE;
      gpioNext   = 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          gpioNext = 1'b0;
          if (sampleStb && burstActive) begin
            ctl.startBurst = 1'b1;
            stateNext      = S_BUSY;
          end
        end
        S_BUSY: begin
          ctl.runCnt = 1'b1;
          if (sts.fallNow) begin
            gpioNext  = 1'b0;
            stateNext = S_IDLE;
          end else if (sts.riseNow && sts.riseOk) begin
            gpioNext = 1'b1;
          end
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      gpioQ <= 1'b0;
    end else begin
      state <= stateNext;
      gpioQ <= gpioNext;
    end
  end

  // R8
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !streamRun |=> !gpioQ);

  // R5
  rise_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gpioQ) |-> $past(sts.riseOk));

  // R4
  fall_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gpioQ) && $past(streamRun)) |-> $past(sts.burstDone));

  // R7
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && !sts.fallNow && streamRun) |=> (state == S_BUSY));

endmodule

// File: rtl/burst_marker.sv
module burst_marker
  import burst_marker_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int CNT_W       = 16,
  parameter int LAT_SAMPLES = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             streamRun,
  input  logic             sampleStb,
  input  logic             burstActive,
  input  logic [DLY_W-1:0] startDly,
  input  logic [DLY_W-1:0] endDly,
  output logic             gpioOut
);

  ctlStb_t ctl;
  dpSts_t  sts;

  burst_marker_dp #(
    .DLY_W      (DLY_W),
    .CNT_W      (CNT_W),
    .LAT_SAMPLES(LAT_SAMPLES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .streamRun  (streamRun),
    .sampleStb  (sampleStb),
    .burstActive(burstActive),
    .startDlyIn (startDly),
    .endDlyIn   (endDly),
    .ctl        (ctl),
    .sts        (sts)
  );

  burst_marker_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .streamRun  (streamRun),
    .sampleStb  (sampleStb),
    .burstActive(burstActive),
    .sts        (sts),
    .ctl        (ctl),
    .gpioQ      (gpioOut)
  );

  initial begin
    latency_param_chk: assert (LAT_SAMPLES >= 1);
  end

endmodule

// File: tb/burst_marker_tb_top.sv
module burst_marker_tb_top;

  localparam int LAT = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        streamRun = 1'b0;
  logic        sampleStb = 1'b0;
  logic        burstActive = 1'b0;
  logic [15:0] startDly = '0;
  logic [15:0] endDly = '0;
  logic        gpioOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int riseCnt = 0;
  int riseCyc = 0;
  int fallCyc = 0;
  int startCyc = 0;
  logic gpioPrev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_marker dut_i (
    .clk(clk), .rstN(rstN), .streamRun(streamRun), .sampleStb(sampleStb),
    .burstActive(burstActive), .startDly(startDly), .endDly(endDly),
    .gpioOut(gpioOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (gpioOut && !gpioPrev) begin
      riseCnt = riseCnt + 1;
      riseCyc = cyc;
    end
    if (!gpioOut && gpioPrev) fallCyc = cyc;
    gpioPrev = gpioOut;
  end

  task automatic check(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int groupLen(input int t);
    return ((t + 3) / 4) * 4;
  endfunction

  task automatic newSession(input int sd, input int ed);
    @(negedge clk);
    streamRun = 1'b0;
    sampleStb = 1'b0;
    burstActive = 1'b0;
    startDly = 16'(sd);
    endDly = 16'(ed);
    repeat (2) @(negedge clk);
    streamRun = 1'b1;
  endtask

  // one sample = two cycles, strobe on the first
  task automatic sendSamples(input int n, input logic act, input bit markStart);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleStb = 1'b1;
      burstActive = act;
      @(negedge clk);
      if (markStart && i == 0) startCyc = cyc;
      sampleStb = 1'b0;
      burstActive = 1'b0;
    end
  endtask

  task automatic burstCase(input int t, input int sd, input int ed,
                           input bit expPulse, input string req);
    int g;
    g = groupLen(t);
    newSession(sd, ed);
    riseCnt = 0;
    sendSamples(t, 1'b1, 1'b1);
    sendSamples(LAT + g + ed / 2 + 8, 1'b0, 1'b0);
    if (expPulse) begin
      check(riseCnt, 1, req, "pulse count");
      check(riseCyc - startCyc, 2 * LAT + sd, "R3", "rise offset");
      check(fallCyc - startCyc, 2 * LAT + 2 * g + ed, "R4", "fall offset");
    end else begin
      check(riseCnt, 0, req, "suppressed pulse count");
    end
  endtask

  task automatic resetCase();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(gpioOut), 0, "R1", "gpio in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(gpioOut), 0, "R1", "gpio after reset, stopped");
  endtask

  task automatic sessionFreezeCase();
    int r1, f1;
    newSession(4, 2);
    riseCnt = 0;
    sendSamples(4, 1'b1, 1'b1);
    sendSamples(LAT + 12, 1'b0, 1'b0);
    r1 = riseCyc - startCyc;
    f1 = fallCyc - startCyc;
    @(negedge clk);
    startDly = 16'd10;
    endDly = 16'd20;
    sendSamples(4, 1'b1, 1'b1);
    sendSamples(LAT + 20, 1'b0, 1'b0);
    check(riseCnt, 2, "R6", "bursts in session");
    check(riseCyc - startCyc, r1, "R6", "second rise offset");
    check(fallCyc - startCyc, f1, "R6", "second fall offset");
    check(r1, 2 * LAT + 4, "R6", "first rise offset");
  endtask

  task automatic lockoutCase();
    newSession(0, 0);
    riseCnt = 0;
    sendSamples(4, 1'b1, 1'b1);
    sendSamples(3, 1'b0, 1'b0);
    sendSamples(4, 1'b1, 1'b0);
    sendSamples(LAT + 10, 1'b0, 1'b0);
    check(riseCnt, 1, "R7", "active samples during pulse");
    // suppressed burst still holds the lock-out
    newSession(10, 0);
    riseCnt = 0;
    sendSamples(2, 1'b1, 1'b1);
    sendSamples(18, 1'b0, 1'b0);
    sendSamples(6, 1'b1, 1'b0);
    sendSamples(LAT + 10, 1'b0, 1'b0);
    check(riseCnt, 0, "R7", "active samples behind suppressed burst");
  endtask

  task automatic offStrobeCase();
    newSession(0, 0);
    riseCnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sampleStb = 1'b1;
      burstActive = 1'b0;
      @(negedge clk);
      sampleStb = 1'b0;
      burstActive = 1'b1;
    end
    @(negedge clk);
    burstActive = 1'b0;
    sendSamples(LAT + 10, 1'b0, 1'b0);
    check(riseCnt, 0, "R2", "flag only off strobe");
  endtask

  task automatic stopCase();
    newSession(0, 0);
    riseCnt = 0;
    sendSamples(8, 1'b1, 1'b1);
    sendSamples(LAT - 4, 1'b0, 1'b0);
    check(int'(gpioOut), 1, "R8", "pulse running before stop");
    @(negedge clk);
    streamRun = 1'b0;
    @(negedge clk);
    check(int'(gpioOut), 0, "R8", "gpio after stop");
    streamRun = 1'b1;
    riseCnt = 0;
    sendSamples(LAT + 12, 1'b0, 1'b0);
    check(riseCnt, 0, "R8", "abandoned pulse after restart");
  endtask

  initial begin
    resetCase();
    burstCase(1, 0, 0, 1'b1, "R4");
    burstCase(5, 0, 0, 1'b1, "R4");
    burstCase(12, 3, 5, 1'b1, "R3");
    burstCase(8, 7, 0, 1'b1, "R3");
    burstCase(5, 8, 2, 1'b1, "R5");
    burstCase(5, 9, 2, 1'b0, "R5");
    burstCase(1, 1, 0, 1'b0, "R5");
    burstCase(3, 4, 6, 1'b1, "R2");
    sessionFreezeCase();
    lockoutCase();
    offStrobeCase();
    stopCase();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule